// File: doc/BRIEF.md
# Triggered Hit Readout Periphery

This block is the digital edge of a pixel matrix. It holds one readout cell per pixel row. When a pixel's discriminator pulses, its cell records the value of a free-running timestamp counter. The stored hit is kept only if a trigger arrives at exactly the programmed number of timestamp ticks after the hit. A cell that sees such a trigger marks itself as triggered. A cell whose waiting time runs out with no trigger empties itself and can take a new hit.

Triggered cells are then drained one at a time onto a shared output bus. The cell with the lowest index goes first. Each word carries the cell's row index and the stored timestamp. The bus uses a valid/ready handshake. While the receiver is not ready, the word on offer does not change. A cell empties in the cycle its word is taken.

Top module: `trig_hit_readout`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid_o` is low and every cell is empty.
- R2: An empty cell that sees `hit_i[r]` high at a clock edge stores the value of `ts_i` at that edge. A cell that is waiting for a trigger, or already triggered, ignores further hits and keeps its stored timestamp.
- R3: Age is defined as `ts_i` minus the stored timestamp. A waiting cell becomes triggered at an edge where `trig_i` is high and its age equals `lat_i`. A trigger at any other age does not trigger it.
- R4: A waiting cell whose age equals `lat_i` at an edge where `trig_i` is low returns to empty. It can then store a new hit.
- R5: The age is computed modulo 2^TS_W, so a hit stored just before the counter wraps is still triggered by a trigger at the correct distance after the wrap.
- R6: The output word has the row index (ROW_W = log2 N_ROWS bits) in its upper bits and the stored timestamp (TS_W bits) in its lower bits.
- R7: When several cells are triggered and no word is being held, the word offered is from the lowest-index triggered cell.
- R8: If `out_valid_o` is high and `out_ready_i` is low at an edge, then in the next cycle `out_valid_o` stays high and `out_word_o` is unchanged. This holds even if a lower-index cell becomes triggered meanwhile.
- R9: A word is taken at an edge where `out_valid_o` and `out_ready_i` are both high. The offering cell empties at that edge, so each triggered hit is delivered exactly once. The cell accepts a new hit from the next cycle on.
- R10: `out_valid_o` is high exactly when at least one cell is triggered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | N_ROWS | Per-row discriminator hit pulses |
| ts_i | input | TS_W | Free-running timestamp counter value, advancing by at most one per clock |
| trig_i | input | 1 | Trigger pulse |
| lat_i | input | TS_W | Trigger latency in timestamp ticks |
| out_ready_i | input | 1 | Receiver ready (read strobe) |
| out_valid_o | output | 1 | A word is on offer |
| out_word_o | output | ROW_W+TS_W | Row index (upper bits) and stored timestamp (lower bits) |

## Verification
The bench builds the block with 16 rows and a 4-bit timestamp. With these values the counter wraps every 16 cycles, so hits stored across the wrap are easy to create. Rows 0 and 15 can be hit together to check both ends of the priority order. The latency is first set to 5 and then changed to 3, so the exact-age match is exercised at two different settings. Triggers one tick early and one tick late check that a trigger at the wrong age is ignored. Holding the ready input low while a lower-index cell becomes triggered checks that the offered word does not change during a stall.

// File: rtl/trh_pkg.sv
package trh_pkg;
  typedef enum logic [1:0] {
    CELL_EMPTY = 2'd0,
    CELL_WAIT  = 2'd1,
    CELL_FLAG  = 2'd2
  } cell_st_e;
endpackage

// File: rtl/trh_cell.sv
module trh_cell
  import trh_pkg::*;
#(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  input  logic [TS_W-1:0] ts_now_i,
  input  logic            trig_i,
  input  logic [TS_W-1:0] lat_i,
  input  logic            take_i,
  output logic            flag_o,
  output logic [TS_W-1:0] ts_o
);
  // modulo distance from the stored stamp to now
  function automatic logic [TS_W-1:0] age_of(input logic [TS_W-1:0] now,
                                             input logic [TS_W-1:0] stamp);
    return now - stamp;
  endfunction

  cell_st_e        state_q;
  logic [TS_W-1:0] ts_q;
  logic            due;
  logic            match;
  logic            lapse;

  assign due    = (state_q == CELL_WAIT) && (age_of(ts_now_i, ts_q) == lat_i);
  assign match  = due && trig_i;
  assign lapse  = due && !trig_i;
  assign flag_o = (state_q == CELL_FLAG);
  assign ts_o   = ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CELL_EMPTY;
      ts_q    <= '0;
    end else begin
      unique case (state_q)
        CELL_EMPTY: if (hit_i) begin
          ts_q    <= ts_now_i;
          state_q <= CELL_WAIT;
        end
        CELL_WAIT: begin
          if (match)      state_q <= CELL_FLAG;
          else if (lapse) state_q <= CELL_EMPTY;
        end
        CELL_FLAG: if (take_i) state_q <= CELL_EMPTY;
        default: state_q <= CELL_EMPTY;
      endcase
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CELL_EMPTY && hit_i) |=> (state_q == CELL_WAIT && ts_q == $past(ts_now_i)));
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CELL_EMPTY) |=> $stable(ts_q));
  p_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (state_q == CELL_FLAG));
  p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lapse |=> (state_q == CELL_EMPTY));
  p_take_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (state_q == CELL_FLAG));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (state_q == CELL_EMPTY));
endmodule

// File: rtl/trh_prio.sv
module trh_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/trh_scan.sv
module trh_scan #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic          accept_o
);
  function automatic logic [N-1:0] below(input logic [IW-1:0] k);
    return (N'(1) << k) - N'(1);
  endfunction

  logic          pe_found;
  logic [IW-1:0] pe_idx;
  logic          hold_q;
  logic [IW-1:0] hold_idx_q;

  trh_prio #(.N(N), .IW(IW)) i_prio (
    .req_i  (req_i),
    .found_o(pe_found),
    .idx_o  (pe_idx)
  );

  // a held offer keeps its index until it is taken
  assign idx_o    = hold_q ? hold_idx_q : pe_idx;
  assign valid_o  = hold_q || pe_found;
  assign accept_o = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= valid_o && !ready_i;
      hold_idx_q <= idx_o;
    end
  end

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !hold_q) |-> ((req_i & below(idx_o)) == '0));
  p_held_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> req_i[idx_o]);
  p_stall_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));
endmodule

// File: rtl/trig_hit_readout.sv
module trig_hit_readout #(
  parameter int N_ROWS = 256,
  parameter int TS_W   = 8,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int WORD_W = ROW_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ROWS-1:0] hit_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              trig_i,
  input  logic [TS_W-1:0]   lat_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o
);
  function automatic logic [WORD_W-1:0] pack_word(input logic [ROW_W-1:0] row,
                                                  input logic [TS_W-1:0] stamp);
    return {row, stamp};
  endfunction

  logic [N_ROWS-1:0] flags;
  logic [N_ROWS-1:0] take;
  logic [TS_W-1:0]   cell_ts [N_ROWS];
  logic [ROW_W-1:0]  grant_idx;
  logic              accept;

  for (genvar g = 0; g < N_ROWS; g++) begin : g_cell
    assign take[g] = accept && (grant_idx == ROW_W'(g));
    trh_cell #(.TS_W(TS_W)) i_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_i[g]),
      .ts_now_i(ts_i),
      .trig_i  (trig_i),
      .lat_i   (lat_i),
      .take_i  (take[g]),
      .flag_o  (flags[g]),
      .ts_o    (cell_ts[g])
    );
  end

  trh_scan #(.N(N_ROWS), .IW(ROW_W)) i_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (flags),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .idx_o   (grant_idx),
    .accept_o(accept)
  );

  assign out_word_o = pack_word(grant_idx, cell_ts[grant_idx]);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_word_o)));
  p_take_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  p_valid_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == (flags != '0));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid_o && flags == '0));
endmodule

// File: tb/test_trig_hit_readout.sv
module test_trig_hit_readout;
  localparam int NR = 16;
  localparam int TW = 4;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] hit = '0;
  logic [TW-1:0] ts = '0;
  logic          trig = 1'b0;
  logic [TW-1:0] lat = 4'd5;
  logic          rdy = 1'b1;
  logic          valid;
  logic [WW-1:0] word;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [WW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  trig_hit_readout #(.N_ROWS(NR), .TS_W(TW)) i_trig_hit_readout (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .ts_i(ts), .trig_i(trig),
    .lat_i(lat), .out_ready_i(rdy), .out_valid_o(valid), .out_word_o(word)
  );

  // expected word: row times 2^TW plus the stamp reduced modulo 2^TW
  function automatic logic [WW-1:0] mk(int row, int stamp);
    return WW'(row * 16 + (stamp % 16));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ts = ts + 1'b1;
    hit = '0;
    trig = 1'b0;
  endtask

  task automatic trig_at(int target);
    while (ts != TW'(target)) step();
    trig = 1'b1;
    step();
  endtask

  task automatic expect_word(int row, int stamp, string req);
    exp_q.push_back(mk(row, stamp));
    tag_q.push_back(req);
  endtask

  task automatic drain(int n, string req);
    repeat (n) step();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(!valid, req, int'(valid), 0);
  endtask

  // monitor: compares every accepted word against the scoreboard
  bit            stall_prev = 0;
  logic [WW-1:0] stall_word = '0;
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (stall_prev)
        chk(valid && word == stall_word, "R8 stall", int'(word), int'(stall_word));
      if (valid && rdy) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected word", int'(word), 0);
        end else begin
          logic [WW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(word == e, t, int'(word), int'(e));
        end
      end
      stall_prev = valid && !rdy;
      stall_word = word;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, s2, s3;
    repeat (3) step();
    chk(!valid, "R1 in reset", int'(valid), 0);
    rst_n = 1'b1;
    step();
    chk(!valid, "R1 after reset", int'(valid), 0);

    // R3 R6: single hit triggered at the exact latency
    step(); hit[3] = 1'b1; s = int'(ts);
    expect_word(3, s, "R3 R6 single");
    trig_at(s + 5);
    drain(6, "R3 single drained");

    // R3: triggers one tick early and late are ignored; R4: cell released
    step(); hit[7] = 1'b1; s = int'(ts);
    trig_at(s + 4);
    trig_at(s + 6);
    drain(6, "R3 wrong age");
    step(); hit[7] = 1'b1; s = int'(ts);
    expect_word(7, s, "R4 reuse after lapse");
    trig_at(s + 5);
    drain(6, "R4 drained");

    // R5: hit stored before the counter wraps
    while (ts != 4'd13) step();
    hit[11] = 1'b1; s = 13;
    expect_word(11, s, "R5 wrap");
    trig_at(s + 5);
    drain(6, "R5 drained");

    // R7: several cells, one trigger, short stall
    step(); hit[9] = 1'b1; hit[2] = 1'b1; hit[14] = 1'b1; s = int'(ts);
    expect_word(2, s, "R7 first");
    expect_word(9, s, "R7 second");
    expect_word(14, s, "R7 third");
    rdy = 1'b0;
    trig_at(s + 5);
    repeat (3) step();
    rdy = 1'b1;
    drain(8, "R7 drained");

    // R8: lower cell triggered during a stall does not replace the offer
    rdy = 1'b0;
    step(); hit[9] = 1'b1; s = int'(ts);
    trig_at(s + 5);
    hit[2] = 1'b1; s2 = int'(ts);
    trig_at(s2 + 5);
    repeat (2) step();
    chk(valid && word == mk(9, s), "R8 held offer", int'(word), int'(mk(9, s)));
    expect_word(9, s, "R8 held first");
    expect_word(2, s2, "R8 lower after");
    rdy = 1'b1;
    drain(6, "R8 drained");

    // R2: second hit while waiting keeps the first stamp
    step(); hit[5] = 1'b1; s = int'(ts);
    step(); step(); hit[5] = 1'b1;
    expect_word(5, s, "R2 first stamp kept");
    trig_at(s + 5);
    trig_at(s + 7);
    drain(6, "R2 waiting drained");

    // R2: hit on a triggered cell ignored; R9 single delivery
    rdy = 1'b0;
    step(); hit[6] = 1'b1; s = int'(ts);
    trig_at(s + 5);
    hit[6] = 1'b1; hit[7] = 1'b1; s2 = int'(ts);
    trig_at(s2 + 5);
    repeat (2) step();
    expect_word(6, s, "R2 flagged first");
    expect_word(7, s2, "R2 neighbour");
    rdy = 1'b1;
    drain(6, "R9 once");
    step(); hit[6] = 1'b1; s3 = int'(ts);
    expect_word(6, s3, "R9 reuse after take");
    trig_at(s3 + 5);
    drain(6, "R9 reuse drained");

    // R3 R7: new latency, boundary rows
    lat = 4'd3;
    step(); hit[0] = 1'b1; hit[15] = 1'b1; s = int'(ts);
    expect_word(0, s, "R3 lat3 row0");
    expect_word(15, s, "R7 lat3 row15");
    trig_at(s + 3);
    drain(6, "R10 idle at end");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule